// File: doc/BRIEF.md
# Streaming YCbCr-to-RGB Pixel Converter

This block rebuilds 8-bit red, green and blue samples from full-range luma and chroma. It accepts one Y, Cb, Cr triple on every clock together with a valid flag and, a fixed three cycles later, presents the matching R, G, B triple with its own valid flag. Because it can take a new pixel on every cycle, it fits directly into a pixel stream.

The first stage removes the mid-scale offset of 128 from both chroma samples and turns them into signed values. The second stage uses three parallel channel datapaths. The red path uses Y and Cr, the blue path uses Y and Cb, and the green path uses all three. Each path forms a signed fixed-point sum with ten fractional bits. The last stage rounds that sum to the nearest integer and clamps it into the 0..255 output range.

Top module: `ycc2rgb`

## Requirements
- R1: Each chroma input has 128 subtracted from it, giving a signed value from -128 to +127. When Cb = Cr = 128, every output equals Y.
- R2: Red is Y + (1434/1024)·(Cr − 128). The coefficient 1434 is round(1.4·1024).
- R3: Green is Y − (351/1024)·(Cb − 128) − (728/1024)·(Cr − 128). The coefficients are round(0.343·1024) and round(0.711·1024).
- R4: Blue is Y + (1807/1024)·(Cb − 128). The coefficient 1807 is round(1.765·1024).
- R5: The red output does not depend on Cb, and the blue output does not depend on Cr.
- R6: The exact fixed-point value is rounded to the nearest integer. A value exactly halfway between two integers rounds upward; for example Y=100, Cb=128, Cr=192 gives G=55.
- R7: A channel result below 0 is output as 0.
- R8: A channel result above 255 is output as 255.
- R9: The output for a pixel appears exactly 3 clock cycles after that pixel is accepted, and `px_vld_o` equals `px_vld_i` delayed by 3 cycles. Pixels may arrive on consecutive cycles.
- R10: While `rst` (synchronous, active high) is asserted, `px_vld_o` is 0 and all three colour outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| px_vld_i | input | 1 | Input pixel valid |
| luma_i | input | 8 | Full-range Y |
| cb_i | input | 8 | Full-range Cb (offset 128) |
| cr_i | input | 8 | Full-range Cr (offset 128) |
| px_vld_o | output | 1 | Output pixel valid |
| red_o | output | 8 | Red result |
| grn_o | output | 8 | Green result |
| blu_o | output | 8 | Blue result |

## Verification
The hardest case to reach is an exact rounding tie. Ties occur only on the green path, and only for specific chroma values. The stimulus applies a hand-picked tie (Cr = 192 with neutral Cb) in addition to random pixels. The clamping corners need saturated luma combined with extreme chroma, so directed pixels drive each path both below 0 and above 255. One stream is sent with Cb changing while Y and Cr stay fixed, which shows that red and blue each ignore the chroma input they must not use.

// File: rtl/ycc2rgb_pkg.sv
package ycc2rgb_pkg;

  // Fixed-point coefficient from a value given in thousandths, rounded.
  function automatic int coef_fx(input int milli, input int frac);
    return (milli * (1 << frac) + 500) / 1000;
  endfunction

  // Round a fixed-point sum to nearest (ties up) and clamp to 0..maxv.
  function automatic int round_clamp(input int acc, input int frac, input int maxv);
    int r;
    r = (acc + (1 << (frac - 1))) >>> frac;
    if (r < 0) r = 0;
    else if (r > maxv) r = maxv;
    return r;
  endfunction

endpackage

// File: rtl/ycc_debias.sv
module ycc_debias #(
  parameter int PIX_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    vld_i,
  input  logic [PIX_W-1:0]        y_i,
  input  logic [PIX_W-1:0]        cb_i,
  input  logic [PIX_W-1:0]        cr_i,
  output logic                    vld_o,
  output logic [PIX_W-1:0]        y_o,
  output logic signed [PIX_W:0]   cb_o,
  output logic signed [PIX_W:0]   cr_o
);
  localparam logic signed [PIX_W:0] BIAS = (PIX_W+1)'(1 << (PIX_W - 1));

  logic signed [PIX_W:0] cb_d, cr_d;
  assign cb_d = $signed({1'b0, cb_i}) - BIAS;
  assign cr_d = $signed({1'b0, cr_i}) - BIAS;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o <= 1'b0;
      y_o   <= '0;
      cb_o  <= '0;
      cr_o  <= '0;
    end else begin
      vld_o <= vld_i;
      y_o   <= y_i;
      cb_o  <= cb_d;
      cr_o  <= cr_d;
    end
  end

  // R1: a mid-scale chroma input becomes zero after offset removal
  a_r1_neutral_chroma: assert property (@(posedge clk) disable iff (rst)
    (cb_i == BIAS[PIX_W-1:0] && cr_i == BIAS[PIX_W-1:0]) |=> (cb_o == 0 && cr_o == 0));

  // R1: the signed result never leaves -128..+127
  a_r1_range: assert property (@(posedge clk) disable iff (rst)
    (cb_o >= -BIAS) && (cb_o < BIAS) && (cr_o >= -BIAS) && (cr_o < BIAS));
endmodule

// File: rtl/ycc_chan.sv
module ycc_chan
  import ycc2rgb_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int FRAC  = 10,
  parameter int CH    = 0    // 0 red, 1 green, 2 blue
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [PIX_W-1:0]       y_i,
  input  logic signed [PIX_W:0]  cb_i,
  input  logic signed [PIX_W:0]  cr_i,
  output logic [PIX_W-1:0]       px_o
);
  localparam int ACC_W = PIX_W + FRAC + 3;
  localparam int KY    = 1 << FRAC;
  localparam int MAXV  = (1 << PIX_W) - 1;
  localparam int K_CB  = (CH == 1) ? -coef_fx(343, FRAC) :
                         (CH == 2) ?  coef_fx(1765, FRAC) : 0;
  localparam int K_CR  = (CH == 0) ?  coef_fx(1400, FRAC) :
                         (CH == 1) ? -coef_fx(711, FRAC) : 0;
  localparam int HI_LIM = MAXV * KY + KY / 2;

  int acc_i;
  logic signed [ACC_W-1:0] acc_q;

  assign acc_i = int'(y_i) * KY + int'(cb_i) * K_CB + int'(cr_i) * K_CR;

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= ACC_W'(acc_i);
  end

  // named events for the checks
  logic acc_neg, acc_over;
  assign acc_neg  = (acc_q < 0);
  assign acc_over = (int'(acc_q) >= HI_LIM);

  always_ff @(posedge clk) begin
    if (rst) px_o <= '0;
    else     px_o <= PIX_W'(round_clamp(int'(acc_q), FRAC, MAXV));
  end

  a_r7_clamp_low: assert property (@(posedge clk) disable iff (rst)
    acc_neg |=> (px_o == '0));

  a_r8_clamp_high: assert property (@(posedge clk) disable iff (rst)
    acc_over |=> (px_o == PIX_W'(MAXV)));

  // R1: zero chroma leaves the luma value unchanged
  a_r1_gray_pass: assert property (@(posedge clk) disable iff (rst)
    (cb_i == 0 && cr_i == 0) |=> ##1 (px_o == $past(y_i, 2)));
endmodule

// File: rtl/ycc2rgb.sv
module ycc2rgb
  import ycc2rgb_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int FRAC  = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             px_vld_i,
  input  logic [PIX_W-1:0] luma_i,
  input  logic [PIX_W-1:0] cb_i,
  input  logic [PIX_W-1:0] cr_i,
  output logic             px_vld_o,
  output logic [PIX_W-1:0] red_o,
  output logic [PIX_W-1:0] grn_o,
  output logic [PIX_W-1:0] blu_o
);
  localparam int NCH = 3;

  logic                  s1_vld;
  logic [PIX_W-1:0]      s1_y;
  logic signed [PIX_W:0] s1_cb, s1_cr;
  logic [1:0]            vld_pipe;
  logic [PIX_W-1:0]      chan_px [NCH];

  ycc_debias #(.PIX_W(PIX_W)) u_debias (
    .clk(clk), .rst(rst), .vld_i(px_vld_i),
    .y_i(luma_i), .cb_i(cb_i), .cr_i(cr_i),
    .vld_o(s1_vld), .y_o(s1_y), .cb_o(s1_cb), .cr_o(s1_cr)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    ycc_chan #(.PIX_W(PIX_W), .FRAC(FRAC), .CH(c)) u_chan (
      .clk(clk), .rst(rst), .y_i(s1_y), .cb_i(s1_cb), .cr_i(s1_cr),
      .px_o(chan_px[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) vld_pipe <= '0;
    else     vld_pipe <= {vld_pipe[0], s1_vld};
  end

  assign px_vld_o = vld_pipe[1];
  assign red_o    = chan_px[0];
  assign grn_o    = chan_px[1];
  assign blu_o    = chan_px[2];

  // cycles since reset, saturating, so that $past never reaches back into reset
  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                since_rst <= '0;
    else if (since_rst != 3) since_rst <= since_rst + 2'd1;
  end

  a_r9_latency: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3) |-> (px_vld_o == $past(px_vld_i, 3)));

  a_r10_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!px_vld_o && red_o == '0 && grn_o == '0 && blu_o == '0));
endmodule

// File: tb/ycc2rgb_test.sv
module ycc2rgb_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic px_vld_i = 1'b0;
  logic [7:0] luma_i = '0, cb_i = '0, cr_i = '0;
  logic px_vld_o;
  logic [7:0] red_o, grn_o, blu_o;

  always #2.5 clk = ~clk;   // 200 MHz

  ycc2rgb uut (
    .clk(clk), .rst(rst), .px_vld_i(px_vld_i),
    .luma_i(luma_i), .cb_i(cb_i), .cr_i(cr_i),
    .px_vld_o(px_vld_o), .red_o(red_o), .grn_o(grn_o), .blu_o(blu_o)
  );

  typedef struct {
    logic [7:0] r, g, b;
    int         due;
    string      tag;
  } exp_t;

  exp_t sb[$];
  int cyc = 0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] sat8(input real v);
    real f;
    f = $floor(v + 0.5);
    if (f < 0.0) return 8'd0;
    if (f > 255.0) return 8'd255;
    return 8'($rtoi(f));
  endfunction

  function automatic real q(input real c);
    return $floor(c * 1024.0 + 0.5) / 1024.0;
  endfunction

  task automatic check8(input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", what, act, exp, cyc);
    end
  endtask

  task automatic send(input logic [7:0] y, input logic [7:0] cb, input logic [7:0] cr,
                      input string tag);
    exp_t e;
    real dcb, dcr;
    dcb = real'(int'(cb)) - 128.0;
    dcr = real'(int'(cr)) - 128.0;
    e.r = sat8(real'(int'(y)) + q(1.4) * dcr);
    e.g = sat8(real'(int'(y)) - q(0.343) * dcb - q(0.711) * dcr);
    e.b = sat8(real'(int'(y)) + q(1.765) * dcb);
    e.due = cyc + 3;
    e.tag = tag;
    sb.push_back(e);
    px_vld_i = 1'b1; luma_i = y; cb_i = cb; cr_i = cr;
    @(negedge clk);
    px_vld_i = 1'b0;
  endtask

  // monitor: sampled on the falling edge
  always @(negedge clk) begin
    if (!rst && px_vld_o) begin
      if (sb.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R9: unexpected output valid, actual 1 expected 0");
      end else begin
        exp_t e;
        e = sb.pop_front();
        n_chk++;
        if (e.due != cyc) begin
          n_bad++;
          $display("FAIL R9: output cycle actual %0d expected %0d", cyc, e.due);
        end
        check8({e.tag, " R2 red"}, red_o, e.r);
        check8({e.tag, " R3 green"}, grn_o, e.g);
        check8({e.tag, " R4 blue"}, blu_o, e.b);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    n_chk++;
    if (px_vld_o !== 1'b0) begin
      n_bad++; $display("FAIL R10: valid actual %0b expected 0", px_vld_o);
    end
    check8("R10 red", red_o, 8'd0);
    check8("R10 green", grn_o, 8'd0);
    check8("R10 blue", blu_o, 8'd0);
    rst = 1'b0;
    @(negedge clk);

    // R1: neutral chroma, outputs equal Y
    send(8'd0, 8'd128, 8'd128, "R1");
    send(8'd77, 8'd128, 8'd128, "R1");
    send(8'd255, 8'd128, 8'd128, "R1");
    repeat (5) @(negedge clk);
    // R6: exact tie on green rounds upward (100 - 45.5 -> 55)
    send(8'd100, 8'd128, 8'd192, "R6");
    // R7: results below zero
    send(8'd0, 8'd0, 8'd0, "R7");
    send(8'd10, 8'd255, 8'd255, "R7");
    // R8: results above 255
    send(8'd255, 8'd255, 8'd255, "R8");
    send(8'd255, 8'd0, 8'd0, "R8");
    repeat (5) @(negedge clk);
    // R5: Cb sweeps with Y and Cr fixed; Cr sweeps with Y and Cb fixed
    for (int k = 0; k < 8; k++) send(8'd120, 8'(k * 33), 8'd150, "R5");
    for (int k = 0; k < 8; k++) send(8'd120, 8'd90, 8'(k * 33), "R5");
    // R9: back-to-back random stream, then gaps
    for (int k = 0; k < 200; k++)
      send(8'($urandom), 8'($urandom), 8'($urandom), "R9");
    for (int k = 0; k < 100; k++) begin
      send(8'($urandom), 8'($urandom), 8'($urandom), "R9");
      repeat ($urandom % 3) @(negedge clk);
    end
    repeat (8) @(negedge clk);
    n_chk++;
    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL R9: pending results actual %0d expected 0", sb.size());
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule